// File: doc/BRIEF.md
# Multi-Mode Sample-Packing Transmit FIFO

This block sits between a 32-bit internal bus and a serial audio or UART shifter. Each bus write carries a packed word and a sample-count code. The two-bit operating mode decides how the word is split into samples. Byte modes yield one, two or four 8-bit samples. The 16-bit codec mode yields one or two 16-bit samples. The AC'97 mode yields exactly one 20-bit time slot, or the 16-bit slot 1 when that slot is flagged.

The samples are queued in write order and handed to the downstream serial engine one at a time over a valid/ready pair. The FIFO reports its fill level and whether it is full or empty. A write that would not fit, or whose count the mode does not allow, is refused as a whole and flagged. Pulsing the transmitter reset, or changing the mode, discards everything held.

Top module: `txpack_fifo`

## Requirements
- R1: During and just after a synchronous `rst`: `empty`=1, `full`=0, `level`=0, `rd_valid`=0, `rd_data`=0, `wr_drop`=0.
- R2: Modes 00 and 01 (byte samples) hold up to 32 samples. For `wr_count` codes 00, 01 and 10, the write holds 1, 2 or 4 samples. The first sample is in bits 31:24 and the following ones are in bits 23:16, 15:8 and 7:0.
- R3: Mode 10 (16-bit samples) holds up to 16 samples. Code 00 stores bits 31:16. Code 01 stores bits 31:16 and then bits 15:0. Code 10 is refused.
- R4: Mode 11 (AC'97) holds up to 16 slots and accepts only code 00. With `wr_slot1`=0 the slot is taken from bits 31:12. With `wr_slot1`=1 it is taken from bits 31:16, zero-extended to 20 bits.
- R5: Samples leave in write order, most significant lane first, on `rd_data` zero-extended to 20 bits. A sample is consumed on a cycle with `rd_valid` and `rd_ready` both high. `rd_data` is 0 while `rd_valid` is low.
- R6: Code 11 is refused in every mode. A refused or oversized write stores nothing. `wr_drop` is high for exactly the cycle after such a write, and `level` changes only by a read made in the same cycle.
- R7: Free space is judged on the level before any read in the same cycle. At 31 of 32, a two-sample write is refused even when a read happens in that cycle.
- R8: `level` equals the number of stored samples. `full` is high when `level` equals the capacity of the current mode. `empty` is high when `level` is 0.
- R9: A cycle with `tx_reset` high empties the FIFO by the next cycle. Any write or read in that cycle is discarded without raising `wr_drop`.
- R10: A cycle whose `mode` differs from the previous cycle's `mode` empties the FIFO in the same way as R9.
- R11: While `rd_valid` is high and `rd_ready` is low, with no flush, `rd_data` and `rd_valid` hold on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 00 UART, 01 8-bit codec, 10 16-bit codec, 11 AC'97 |
| tx_reset | input | 1 | Transmitter reset, flushes contents |
| wr_en | input | 1 | Bus write strobe |
| wr_count | input | 2 | Sample count: 00 one, 01 two, 10 four, 11 illegal |
| wr_slot1 | input | 1 | AC'97: this write is the 16-bit slot 1 |
| wr_data | input | 32 | Packed bus word |
| rd_ready | input | 1 | Serial engine takes the head sample |
| rd_valid | output | 1 | A sample is available |
| rd_data | output | 20 | Head sample, zero-extended |
| level | output | 6 | Number of stored samples |
| full | output | 1 | Level equals mode capacity |
| empty | output | 1 | No samples stored |
| wr_drop | output | 1 | Previous-cycle write was refused |

## Verification
The bench works on the fill boundary. It fills to exactly 32 and to exactly 16, then writes once more. A design that checked capacity against the wrong mode would accept the extra write or refuse the last legal one. At a level of 31 it issues a two-sample write together with a read. A design that counted the read toward free space would accept that write and store one sample too many. Lane order is checked in every mode, and in AC'97 the slot-1 alignment is checked on its own: a swapped lane or a left-aligned slot 1 shows up at once on `rd_data`. Flushes are also triggered on the same cycle as a write and a read. A design that let either of them through, or raised `wr_drop` on a flush, would leave a nonzero level or a stray pulse.

// File: rtl/txpack_pkg.sv
package txpack_pkg;

  typedef enum logic [1:0] {
    MODE_UART = 2'b00,
    MODE_C8   = 2'b01,
    MODE_C16  = 2'b10,
    MODE_AC   = 2'b11
  } txmode_e;

  // samples carried by one write; 0 marks a count the mode refuses
  function automatic logic [2:0] cnt_samples(input logic [1:0] m, input logic [1:0] c);
    logic [2:0] n;
    case (c)
      2'b00:   n = 3'd1;
      2'b01:   n = 3'd2;
      2'b10:   n = 3'd4;
      default: n = 3'd0;
    endcase
    if (m == MODE_C16 && n == 3'd4) n = 3'd0;
    if (m == MODE_AC && n != 3'd1)  n = 3'd0;
    return n;
  endfunction

endpackage

// File: rtl/txpack_lanes.sv
module txpack_lanes
  import txpack_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int SAMP_W = 20,
  parameter int LANES  = 4
) (
  input  logic [1:0]                   mode,
  input  logic                         slot1,
  input  logic [BUS_W-1:0]             bus,
  output logic [LANES-1:0][SAMP_W-1:0] lane
);
  localparam int BW = BUS_W / LANES;   // byte lane width
  localparam int HW = 2 * BW;          // half-word lane width

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [SAMP_W-1:0] b_v, h_v, a_v;

    assign b_v = SAMP_W'(bus[BUS_W-1-BW*k -: BW]);

    if (k < LANES/2) begin : g_half
      assign h_v = SAMP_W'(bus[BUS_W-1-HW*k -: HW]);
    end else begin : g_nohalf
      assign h_v = '0;
    end

    if (k == 0) begin : g_slot
      assign a_v = slot1 ? SAMP_W'(bus[BUS_W-1 -: HW]) : bus[BUS_W-1 -: SAMP_W];
    end else begin : g_noslot
      assign a_v = '0;
    end

    assign lane[k] = (mode == MODE_C16) ? h_v :
                     (mode == MODE_AC)  ? a_v : b_v;
  end
endmodule

// File: rtl/txpack_ring.sv
module txpack_ring #(
  parameter int DEPTH  = 32,
  parameter int SAMP_W = 20,
  parameter int LANES  = 4,
  localparam int AW    = $clog2(DEPTH),
  localparam int LW    = AW + 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clr,
  input  logic [2:0]                   push_n,
  input  logic [LANES-1:0][SAMP_W-1:0] lane,
  input  logic                         pop,
  output logic [SAMP_W-1:0]            head,
  output logic [LW-1:0]                level
);
  logic [SAMP_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp, rp;

  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++) begin
      if (k < int'(push_n)) mem[wp + AW'(k)] <= lane[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      wp    <= wp + AW'(push_n);
      rp    <= rp + AW'(pop);
      level <= level + LW'(push_n) - LW'(pop);
    end
  end

  assign head = mem[rp];
endmodule

// File: rtl/txpack_fifo.sv
module txpack_fifo
  import txpack_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int SAMP_W = 20,
  parameter int DEPTH  = 32,
  parameter int LANES  = 4,
  localparam int LW    = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic              tx_reset,
  input  logic              wr_en,
  input  logic [1:0]        wr_count,
  input  logic              wr_slot1,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [SAMP_W-1:0] rd_data,
  output logic [LW-1:0]     level,
  output logic              full,
  output logic              empty,
  output logic              wr_drop
);
  logic [1:0]                   mode_q;
  logic                         flush, accept, pop, fits;
  logic [2:0]                   n_req, push_n;
  logic [LW-1:0]                cap;
  logic [LW:0]                  need;
  logic [LANES-1:0][SAMP_W-1:0] lane;
  logic [SAMP_W-1:0]            head;

  assign flush  = tx_reset || (mode != mode_q);
  assign cap    = (mode_q == MODE_C16 || mode_q == MODE_AC) ? LW'(DEPTH/2) : LW'(DEPTH);
  assign n_req  = cnt_samples(mode_q, wr_count);
  assign need   = {1'b0, level} + (LW+1)'(n_req);
  assign fits   = need <= {1'b0, cap};
  assign accept = wr_en && !flush && (n_req != 3'd0) && fits;
  assign push_n = accept ? n_req : 3'd0;
  assign pop    = rd_valid && rd_ready && !flush;

  always_ff @(posedge clk) begin
    mode_q <= mode;
    if (rst) wr_drop <= 1'b0;
    else     wr_drop <= wr_en && !flush && !accept;
  end

  txpack_lanes #(.BUS_W(BUS_W), .SAMP_W(SAMP_W), .LANES(LANES)) u_lanes (
    .mode  (mode_q),
    .slot1 (wr_slot1),
    .bus   (wr_data),
    .lane  (lane)
  );

  txpack_ring #(.DEPTH(DEPTH), .SAMP_W(SAMP_W), .LANES(LANES)) u_ring (
    .clk    (clk),
    .rst    (rst),
    .clr    (flush),
    .push_n (push_n),
    .lane   (lane),
    .pop    (pop),
    .head   (head),
    .level  (level)
  );

  assign rd_valid = (level != '0);
  assign rd_data  = rd_valid ? head : '0;
  assign full     = (level == cap);
  assign empty    = (level == '0);
endmodule

// File: rtl/txpack_fifo_chk.sv
module txpack_fifo_chk #(
  parameter int DEPTH  = 32,
  parameter int SAMP_W = 20,
  parameter int LW     = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        mode,
  input logic              tx_reset,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [SAMP_W-1:0] rd_data,
  input logic [LW-1:0]     level,
  input logic              full,
  input logic              empty,
  input logic              wr_drop
);
  logic [1:0] prev_mode;
  always_ff @(posedge clk) prev_mode <= mode;

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    empty |-> (!rd_valid && rd_data == '0)); // R5
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
    level <= LW'(DEPTH)); // R8
  AST_FULL_EMPTY: assert property (@(posedge clk) disable iff (rst)
    !(full && empty)); // R8
  AST_TXRST_CLEAR: assert property (@(posedge clk) disable iff (rst)
    tx_reset |=> (empty && level == '0)); // R9
  AST_MODE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (mode != prev_mode) |=> empty); // R10
  AST_DROP_HOLD: assert property (@(posedge clk) disable iff (rst)
    wr_drop |-> level == $past(level) - LW'($past(rd_valid && rd_ready))); // R6
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready && !tx_reset && mode == prev_mode) |=> (rd_valid && $stable(rd_data))); // R11
endmodule

bind txpack_fifo txpack_fifo_chk #(.DEPTH(DEPTH), .SAMP_W(SAMP_W), .LW(LW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mode     (mode),
  .tx_reset (tx_reset),
  .rd_valid (rd_valid),
  .rd_ready (rd_ready),
  .rd_data  (rd_data),
  .level    (level),
  .full     (full),
  .empty    (empty),
  .wr_drop  (wr_drop)
);

// File: tb/test_txpack_fifo.sv
`timescale 1ns/1ps
module test_txpack_fifo;
  logic        clk = 1'b0;
  logic        rst, tx_reset, wr_en, wr_slot1, rd_ready;
  logic [1:0]  mode, wr_count;
  logic [31:0] wr_data;
  logic        rd_valid, full, empty, wr_drop;
  logic [19:0] rd_data;
  logic [5:0]  level;

  always #2 clk = ~clk;

  txpack_fifo i_txpack_fifo (
    .clk(clk), .rst(rst), .mode(mode), .tx_reset(tx_reset), .wr_en(wr_en),
    .wr_count(wr_count), .wr_slot1(wr_slot1), .wr_data(wr_data), .rd_ready(rd_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .level(level), .full(full),
    .empty(empty), .wr_drop(wr_drop)
  );

  int         q[$];
  logic [1:0] mprev;
  bit         exp_drop;
  int         vectors = 0, errs = 0;
  string      req = "R1";

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, tag, act, exp);
    end
  endtask

  function automatic int sample(int k);
    case (mode)
      2'b10:   return int'((wr_data >> (16 - 16*k)) & 32'hFFFF);            // R3
      2'b11:   return wr_slot1 ? int'(wr_data[31:16]) : int'(wr_data[31:12]); // R4
      default: return int'((wr_data >> (24 - 8*k)) & 32'hFF);              // R2
    endcase
  endfunction

  task automatic model();
    int n, cap;
    bit legal, pop;
    if (rst || tx_reset || mode != mprev) begin   // R1 R9 R10
      q.delete();
      exp_drop = 0;
    end else begin
      n = (wr_count == 2'd0) ? 1 : (wr_count == 2'd1) ? 2 : (wr_count == 2'd2) ? 4 : 0;
      case (mode)
        2'b00, 2'b01: legal = (n != 0);
        2'b10:        legal = (n == 1 || n == 2);
        default:      legal = (n == 1);
      endcase
      cap = (mode >= 2'b10) ? 16 : 32;
      pop = (q.size() > 0) && rd_ready;
      if (wr_en && legal && q.size() + n <= cap) begin   // R7: space before pop
        if (pop) void'(q.pop_front());
        for (int k = 0; k < n; k++) q.push_back(sample(k));
        exp_drop = 0;
      end else begin
        if (pop) void'(q.pop_front());
        exp_drop = wr_en;                                 // R6
      end
    end
    mprev = mode;
  endtask

  task automatic compare();
    int cap;
    cap = (mprev >= 2'b10) ? 16 : 32;
    chk("rd_valid(R5)", int'(rd_valid), int'(q.size() > 0));
    chk("rd_data(R5)",  int'(rd_data),  (q.size() > 0) ? q[0] : 0);
    chk("level(R8)",    int'(level),    q.size());
    chk("full(R8)",     int'(full),     int'(q.size() == cap));
    chk("empty(R8)",    int'(empty),    int'(q.size() == 0));
    chk("wr_drop(R6)",  int'(wr_drop),  int'(exp_drop));
  endtask

  task automatic cyc();
    model();
    @(negedge clk);
    compare();
  endtask

  task automatic drive(bit en, logic [1:0] cnt, logic [31:0] d, bit s1, bit rdy);
    wr_en = en; wr_count = cnt; wr_data = d; wr_slot1 = s1; rd_ready = rdy;
    cyc();
  endtask

  initial begin
    #(4 * 150000);
    errs++;
    $display("FAIL WATCHDOG: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    rst = 1; tx_reset = 0; mode = 2'b00; mprev = 2'b00;
    wr_en = 0; wr_count = 0; wr_data = 0; wr_slot1 = 0; rd_ready = 0;
    @(negedge clk);
    // R1: reset state
    req = "R1";
    cyc(); cyc();
    rst = 0;
    drive(0, 0, 0, 0, 0);

    // R2: byte lanes, 1/2/4 samples, drained in order (R5)
    req = "R2";
    drive(1, 2'd0, 32'hA1_00_00_00, 0, 0);
    drive(1, 2'd1, 32'hB1_B2_00_00, 0, 0);
    drive(1, 2'd2, 32'hC1_C2_C3_C4, 0, 0);
    req = "R5";
    repeat (8) drive(0, 0, 0, 0, 1);

    // R2 fill to 32, then oversized write refused (R6)
    req = "R2";
    for (int i = 0; i < 8; i++) drive(1, 2'd2, 32'h10203040 + 32'(i), 0, 0);
    req = "R6";
    drive(1, 2'd0, 32'hEE000000, 0, 0);
    drive(0, 0, 0, 0, 0);

    // R7: at 31, two-sample write with a read is refused; one-sample accepted
    req = "R7";
    drive(0, 0, 0, 0, 1);
    drive(1, 2'd1, 32'hDDCC0000, 0, 1);
    drive(1, 2'd0, 32'h77000000, 0, 1);
    drive(0, 0, 0, 0, 0);

    // R11: head holds with ready low
    req = "R11";
    repeat (3) drive(0, 0, 0, 0, 0);

    // R10: mode change with write and read in the same cycle
    req = "R10";
    mode = 2'b01;
    drive(1, 2'd2, 32'h11223344, 0, 1);
    req = "R6";
    drive(1, 2'd3, 32'h55667788, 0, 0);     // code 11 illegal
    req = "R2";
    drive(1, 2'd1, 32'h99AA0000, 0, 0);
    drive(0, 0, 0, 0, 1);

    // R3: 16-bit mode
    req = "R3";
    mode = 2'b10;
    drive(0, 0, 0, 0, 0);
    drive(1, 2'd0, 32'h1234_0000, 0, 0);
    drive(1, 2'd1, 32'hABCD_EF01, 0, 0);
    drive(1, 2'd2, 32'h5555_AAAA, 0, 0);    // four refused in this mode
    for (int i = 0; i < 7; i++) drive(1, 2'd1, 32'h0F0F_0000 + 32'(i), 0, 0);
    drive(1, 2'd0, 32'hFFFF_0000, 0, 0);    // exactly 16
    drive(1, 2'd0, 32'h2222_0000, 0, 0);    // overflow
    repeat (17) drive(0, 0, 0, 0, 1);

    // R4: AC'97 slots
    req = "R4";
    mode = 2'b11;
    drive(0, 0, 0, 0, 0);
    drive(1, 2'd0, 32'hBEEF_1234, 1, 0);    // slot 1: 16 bits zero-extended
    drive(1, 2'd0, 32'hCAFE_5678, 0, 0);    // 20-bit slot
    drive(1, 2'd1, 32'h1111_1111, 0, 0);    // two slots refused
    for (int i = 0; i < 14; i++) drive(1, 2'd0, 32'h8000_0000 + 32'(i << 12), 0, 0);
    drive(1, 2'd0, 32'h1234_5000, 0, 0);    // overflow
    repeat (4) drive(0, 0, 0, 0, 1);

    // R9: transmitter reset with write and read pending
    req = "R9";
    tx_reset = 1;
    drive(1, 2'd0, 32'h4444_4000, 0, 1);
    tx_reset = 0;
    drive(0, 0, 0, 0, 0);

    // random traffic across all requirements
    req = "RND";
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 199) == 0) mode = 2'($urandom);
      tx_reset = ($urandom_range(0, 299) == 0);
      drive(($urandom_range(0, 2) != 0), 2'($urandom), $urandom,
            ($urandom_range(0, 3) == 0), ($urandom_range(0, 2) == 0));
    end
    tx_reset = 0;

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule